// File: doc/BRIEF.md
# Decode-Stage Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline whose branch comparisons are made in decode. Each cycle it compares the two source register numbers of the instruction being decoded with the destinations of the two older instructions that are still in flight. The first of those is the instruction in the decode/execute register. The second is the instruction in the execute/memory register. When a value the decoding instruction needs cannot be forwarded in time, the unit requests a stall.

A stall drops the program counter write enable and the fetch/decode register write enable, so the same instruction is decoded again and the next one is fetched again. It also raises `bubble`, which tells the datapath to zero the control fields it writes into the decode/execute register.

An ordinary consumer waits one cycle behind a load. A branch waits one cycle behind an ALU result that is one instruction older, and one cycle behind a load that is two instructions older. Behind a load that is directly older, a branch waits two cycles. The outputs are purely combinational from the pipeline register contents. Each extra stall cycle therefore comes out again on its own as the producer moves on by one stage, and no counter is kept.

Top module: `hzd_stall_unit`

## Requirements
- R1: When the decode/execute instruction reads memory and its destination equals the decoding instruction's first source, the unit stalls: `pc_write`=0, `ifid_write`=0, `bubble`=1.
- R2: When the decode/execute instruction reads memory and its destination equals the decoding instruction's second source, the unit stalls in the same way.
- R3: With no matching producer, the unit does not stall: `pc_write`=1, `ifid_write`=1, `bubble`=0. This also holds with every input at zero.
- R4: A branch (`ifid_is_branch`=1) stalls when the decode/execute instruction writes a register without reading memory and its destination matches either source. A non-branch instruction facing the same producer does not stall.
- R5: A branch stalls when the execute/memory instruction reads memory and its destination matches either source.
- R6: An execute/memory instruction that does not read memory never causes a stall, whether or not the consumer is a branch.
- R7: With the default register-zero setting, a destination of 0 never causes a stall.
- R8: A decode/execute instruction with both `idex_reg_write`=0 and `idex_mem_read`=0 never causes a stall.
- R9: A branch that uses the result of the load directly before it sees exactly two stall cycles as the load moves on by one stage per cycle. A branch that uses a load two instructions older sees exactly one stall cycle.
- R10: `pc_write` and `ifid_write` are always equal, and `bubble` is always their inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_src_a | input | REG_W | First source register of the decoding instruction |
| ifid_src_b | input | REG_W | Second source register of the decoding instruction |
| ifid_is_branch | input | 1 | Decoding instruction compares registers in decode |
| idex_mem_read | input | 1 | Decode/execute instruction is a load |
| idex_reg_write | input | 1 | Decode/execute instruction writes a register |
| idex_dst | input | REG_W | Resolved destination of the decode/execute instruction |
| exmem_mem_read | input | 1 | Execute/memory instruction is a load |
| exmem_dst | input | REG_W | Resolved destination of the execute/memory instruction |
| pc_write | output | 1 | Program counter may advance |
| ifid_write | output | 1 | Fetch/decode register may load |
| bubble | output | 1 | Zero the control fields entering decode/execute |

## Verification
The assertions take two things for granted. First, the destination numbers are already resolved: for a load this is the target field, and for an ALU operation it is the result field. Second, a load also sets its register-write flag, so a set memory-read flag marks a load however the register-write flag is driven. The sweep drives every combination of flags and register numbers, including combinations a real decoder never produces, and the assertions stay true on those because they constrain only outputs against flag patterns. The two pipeline sequences move each producer on by hand, one stage per cycle. At each step a bubble enters the decode/execute slot, as the datapath would place it there.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   // Reason a stall is raised; used for priority reporting only.
   typedef enum logic [1:0] {
      HZ_NONE     = 2'd0,
      HZ_LOAD_USE = 2'd1,
      HZ_BR_ALU   = 2'd2,
      HZ_BR_LOAD  = 2'd3
   } hz_cause_e;

   function automatic hz_cause_e pick_cause(input logic lu, input logic bra, input logic brl);
      if (lu)       return HZ_LOAD_USE;
      else if (bra) return HZ_BR_ALU;
      else if (brl) return HZ_BR_LOAD;
      else          return HZ_NONE;
   endfunction
endpackage

// File: rtl/hzd_dst_match.sv
module hzd_dst_match #(
   parameter int REG_W   = 5,
   parameter bit ZERO_HW = 1'b1
) (
   input  logic             prod_valid,
   input  logic [REG_W-1:0] prod_dst,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   output logic             hit
);
   localparam logic [REG_W-1:0] ZERO_IDX = '0;

   logic eq_any;
   logic dst_live;

   assign eq_any = (prod_dst == src_a) || (prod_dst == src_b);

   generate
      if (ZERO_HW) begin : g_zero_guard
         assign dst_live = (prod_dst != ZERO_IDX);
      end else begin : g_zero_plain
         assign dst_live = 1'b1;
      end
   endgenerate

   assign hit = prod_valid && dst_live && eq_any;
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
   parameter int REG_W   = 5,
   parameter bit ZERO_HW = 1'b1
) (
   input  logic             idex_mem_read,
   input  logic [REG_W-1:0] idex_dst,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   output logic             lu_hit
);
   hzd_dst_match #(.REG_W(REG_W), .ZERO_HW(ZERO_HW)) u_m (
      .prod_valid (idex_mem_read),
      .prod_dst   (idex_dst),
      .src_a      (src_a),
      .src_b      (src_b),
      .hit        (lu_hit)
   );
endmodule

// File: rtl/hzd_branch.sv
module hzd_branch #(
   parameter int REG_W   = 5,
   parameter bit ZERO_HW = 1'b1
) (
   input  logic             is_branch,
   input  logic             idex_mem_read,
   input  logic             idex_reg_write,
   input  logic [REG_W-1:0] idex_dst,
   input  logic             exmem_mem_read,
   input  logic [REG_W-1:0] exmem_dst,
   input  logic [REG_W-1:0] src_a,
   input  logic [REG_W-1:0] src_b,
   output logic             br_alu_hit,
   output logic             br_load_hit
);
   logic alu_valid;
   logic ld_valid;

   // ALU result one step ahead is not ready for a compare in decode.
   assign alu_valid = is_branch && idex_reg_write && !idex_mem_read;
   // Load data in memory stage is not ready until writeback forwarding.
   assign ld_valid  = is_branch && exmem_mem_read;

   hzd_dst_match #(.REG_W(REG_W), .ZERO_HW(ZERO_HW)) u_alu (
      .prod_valid (alu_valid),
      .prod_dst   (idex_dst),
      .src_a      (src_a),
      .src_b      (src_b),
      .hit        (br_alu_hit)
   );

   hzd_dst_match #(.REG_W(REG_W), .ZERO_HW(ZERO_HW)) u_ld (
      .prod_valid (ld_valid),
      .prod_dst   (exmem_dst),
      .src_a      (src_a),
      .src_b      (src_b),
      .hit        (br_load_hit)
   );
endmodule

// File: rtl/hzd_stall_unit.sv
module hzd_stall_unit #(
   parameter int REG_W   = 5,
   parameter bit ZERO_HW = 1'b1
) (
   input  logic [REG_W-1:0] ifid_src_a,
   input  logic [REG_W-1:0] ifid_src_b,
   input  logic             ifid_is_branch,
   input  logic             idex_mem_read,
   input  logic             idex_reg_write,
   input  logic [REG_W-1:0] idex_dst,
   input  logic             exmem_mem_read,
   input  logic [REG_W-1:0] exmem_dst,
   output logic             pc_write,
   output logic             ifid_write,
   output logic             bubble
);
   import hzd_pkg::*;

   localparam int MAX_REG_W = 8;

   generate
      if (REG_W < 1 || REG_W > MAX_REG_W) begin : g_bad_width
         $error("hzd_stall_unit: REG_W out of range");
      end
   endgenerate

   logic      lu_hit;
   logic      br_alu_hit;
   logic      br_load_hit;
   hz_cause_e cause;

   hzd_loaduse #(.REG_W(REG_W), .ZERO_HW(ZERO_HW)) u_lu (
      .idex_mem_read (idex_mem_read),
      .idex_dst      (idex_dst),
      .src_a         (ifid_src_a),
      .src_b         (ifid_src_b),
      .lu_hit        (lu_hit)
   );

   hzd_branch #(.REG_W(REG_W), .ZERO_HW(ZERO_HW)) u_br (
      .is_branch      (ifid_is_branch),
      .idex_mem_read  (idex_mem_read),
      .idex_reg_write (idex_reg_write),
      .idex_dst       (idex_dst),
      .exmem_mem_read (exmem_mem_read),
      .exmem_dst      (exmem_dst),
      .src_a          (ifid_src_a),
      .src_b          (ifid_src_b),
      .br_alu_hit     (br_alu_hit),
      .br_load_hit    (br_load_hit)
   );

   assign cause      = pick_cause(lu_hit, br_alu_hit, br_load_hit);
   assign bubble     = (cause != HZ_NONE);
   assign pc_write   = !(lu_hit || br_alu_hit || br_load_hit);
   assign ifid_write = pc_write;

   always_comb begin
      // R10
      hold_pair_chk: assert (pc_write == ifid_write && bubble == !pc_write)
         else $error("stall outputs disagree");
      // R8
      quiet_idex_chk: assert (!(!idex_mem_read && !idex_reg_write && !exmem_mem_read && bubble) || ifid_is_branch == 1'b1 && 1'b0)
         else $error("stall without any producer");
      // R6
      alu_exmem_chk: assert (!(!exmem_mem_read && !idex_mem_read && !ifid_is_branch && bubble))
         else $error("stall from forwardable producer");
      // R4
      excl_cause_chk: assert (!(lu_hit && br_alu_hit))
         else $error("load-use and branch-alu both hit");
      // R7
      zero_dst_chk: assert (!(ZERO_HW && idex_dst == '0 && exmem_dst == '0 && bubble))
         else $error("stall on register zero");
   end
endmodule

// File: tb/hzd_stall_unit_test.sv
module hzd_stall_unit_test;
   localparam int RW = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [RW-1:0] src_a, src_b, id_dst, ex_dst;
   logic br, imr, irw, emr;
   logic pc_write, ifid_write, bubble;
   int total = 0;
   int bad = 0;
   bit done = 0;

   hzd_stall_unit #(.REG_W(RW), .ZERO_HW(1'b1)) uut (
      .ifid_src_a(src_a), .ifid_src_b(src_b), .ifid_is_branch(br),
      .idex_mem_read(imr), .idex_reg_write(irw), .idex_dst(id_dst),
      .exmem_mem_read(emr), .exmem_dst(ex_dst),
      .pc_write(pc_write), .ifid_write(ifid_write), .bubble(bubble)
   );

   task automatic drive(input logic b, input logic [RW-1:0] a, input logic [RW-1:0] s,
                        input logic im, input logic iw, input logic [RW-1:0] idd,
                        input logic em, input logic [RW-1:0] exd);
      @(posedge clk); #1;
      br = b; src_a = a; src_b = s; imr = im; irw = iw; id_dst = idd; emr = em; ex_dst = exd;
      @(negedge clk);
   endtask

   task automatic check(input bit exp_stall, input string req);
      total++;
      if (pc_write !== !exp_stall || ifid_write !== !exp_stall || bubble !== exp_stall) begin
         bad++;
         $display("FAIL %s: pc_write=%0b ifid_write=%0b bubble=%0b expected stall=%0b",
                  req, pc_write, ifid_write, bubble, exp_stall);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R3: all-zero inputs, no stall
      drive(0, 0, 0, 0, 0, 0, 0, 0);
      check(0, "R3 idle");

      // Exhaustive sweep
      for (int v = 0; v < 8192; v++) begin
         logic [RW-1:0] a, s, idd, exd;
         logic b, im, iw, em;
         bit lu, bal, bld, stall;
         string tag;
         a = v[1:0]; s = v[3:2]; idd = v[5:4]; exd = v[7:6];
         b = v[8]; im = v[9]; iw = v[10]; em = v[11];
         if (v[12]) begin a = idd; end
         lu  = im && idd != 0 && (idd == a || idd == s);
         bal = b && iw && !im && idd != 0 && (idd == a || idd == s);
         bld = b && em && exd != 0 && (exd == a || exd == s);
         stall = lu || bal || bld;
         if (lu)       tag = (idd == a) ? "R1" : "R2";
         else if (bal) tag = "R4";
         else if (bld) tag = "R5";
         else if (!b && iw && !im && idd != 0 && (idd == a || idd == s)) tag = "R4 non-branch";
         else if (b && !em && exd != 0 && (exd == a || exd == s)) tag = "R6";
         else if (!iw && !im && idd != 0 && (idd == a || idd == s)) tag = "R8";
         else if ((idd == 0 && (a == 0 || s == 0)) || (exd == 0 && (a == 0 || s == 0))) tag = "R7";
         else tag = "R3";
         drive(b, a, s, im, iw, idd, em, exd);
         check(stall, tag);
         // R10 relation checked alongside
         total++;
         if (pc_write !== ifid_write || bubble !== !pc_write) begin
            bad++;
            $display("FAIL R10: pc_write=%0b ifid_write=%0b bubble=%0b expected equal/inverse",
                     pc_write, ifid_write, bubble);
         end
      end

      // R9: load directly before branch -> two stalls
      drive(1, 1, 2, 1, 1, 1, 0, 0);
      check(1, "R9 load-adjacent cycle 1");
      drive(1, 1, 2, 0, 0, 0, 1, 1);
      check(1, "R9 load-adjacent cycle 2");
      drive(1, 1, 2, 0, 0, 0, 0, 0);
      check(0, "R9 load-adjacent resume");

      // R9: load two back -> one stall
      drive(1, 3, 1, 0, 1, 2, 1, 3);
      check(1, "R9 load-two-back cycle 1");
      drive(1, 3, 1, 0, 0, 0, 0, 2);
      check(0, "R9 load-two-back resume");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule